// File: doc/BRIEF.md
# Basic-Mode 24-Line Parallel Port with Driver Gating

This block gives a processor 24 general-purpose I/O lines split into four groups: two full-width byte groups (A and B) and a third byte (C) whose upper and lower nibbles are configured on their own. It runs in basic mode only, with no strobes and no handshaking. Each group is either an input, whose pins are read live, or an output, whose value sits in a register until software rewrites it. The processor reaches the block through a 2-bit address, separate write and read strobes, and a byte-wide data bus. Offsets 0, 1 and 2 select the data of groups A, B and C. Offset 3 is a write-only control byte.

All external drivers pass through a global gate. Every control write copies its top bit into a driver-disable flag. While that flag is set, every output enable is held low, whatever the directions are. The usual bring-up therefore takes two writes: first the direction byte with the top bit set, which leaves the pins floating, and then a byte with the top bit clear, which opens the drivers. A strap input can bypass the flag so that only the directions decide which pins are driven.

Top module: `pio24_port`

## Requirements
- R1: While reset is asserted, and after it is released, all four groups are inputs, the driver-disable flag is set, all output enables are 0 and all output registers hold zero.
- R2: A control write with bit 7 = 1 loads the directions. Bit 4 sets group A, bit 1 group B, bit 3 the high nibble of C (lines 7..4) and bit 0 the low nibble of C (lines 3..0). A 1 makes the group an input and a 0 makes it an output. Writing 0x80 makes all four groups outputs.
- R3: A control write with bit 7 = 1 sets the driver-disable flag. While the flag is set and the strap is low, every output enable is 0.
- R4: A control write with bit 7 = 0 clears the driver-disable flag and changes neither the directions nor any output register. No single-bit set or reset of group C takes place.
- R5: While the strap input is 1, the output enable of each line is 1 exactly when its group is an output, whatever the state of the flag.
- R6: A write to offset 0, 1 or 2 stores the data byte in the output register of group A, B or C, respectively. That register drives the group's output pins and keeps its value until the next write to the same offset.
- R7: A read of offset 0, 1 or 2 returns, for each group or nibble, the live input pins if it is an input and its output register if it is an output.
- R8: A read of offset 3 returns 0x00, and rdata is 0x00 whenever the read strobe is low.
- R9: Control bits 2, 5 and 6 have no effect. A control write that differs from another only in these bits gives the same directions and flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| drv_strap | input | 1 | 1 keeps the drivers enabled regardless of the disable flag |
| addr | input | 2 | Register offset |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| rd_en | input | 1 | Read strobe; rdata is valid while it is high |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| pa_in | input | 8 | Group A pin input |
| pa_out | output | 8 | Group A output register |
| pa_oe | output | 8 | Group A per-line output enable |
| pb_in | input | 8 | Group B pin input |
| pb_out | output | 8 | Group B output register |
| pb_oe | output | 8 | Group B per-line output enable |
| pc_in | input | 8 | Group C pin input |
| pc_out | output | 8 | Group C output register |
| pc_oe | output | 8 | Group C per-line output enable (per nibble) |

## Verification
The bench builds the block with its default byte width of 8. At that width the control byte has exactly the bit positions the requirements name, and group C splits into two 4-bit nibbles. This width makes the mixed-direction read reachable, where one half of C returns live pins and the other half returns its register. It also covers the two-write enable sequence and the interaction between the strap and the disable flag.

// File: rtl/pio24_pkg.sv
package pio24_pkg;
   typedef enum logic [1:0] {
      OFS_A    = 2'd0,
      OFS_B    = 2'd1,
      OFS_C    = 2'd2,
      OFS_CTRL = 2'd3
   } pio_ofs_e;

   localparam int unsigned CB_CLO  = 0;
   localparam int unsigned CB_B    = 1;
   localparam int unsigned CB_CHI  = 3;
   localparam int unsigned CB_A    = 4;
   localparam int unsigned CB_SET  = 7;
endpackage

// File: rtl/pio24_ctrl.sv
module pio24_ctrl #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [BYTE_W-1:0] wdata,
   output logic              dir_a,
   output logic              dir_b,
   output logic              dir_chi,
   output logic              dir_clo,
   output logic              buf_off
);
   import pio24_pkg::*;

   initial begin
      if (BYTE_W < CB_SET + 1) $error("BYTE_W too small for control byte");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_a   <= 1'b1;
         dir_b   <= 1'b1;
         dir_chi <= 1'b1;
         dir_clo <= 1'b1;
         buf_off <= 1'b1;
      end else if (wr) begin
         buf_off <= wdata[CB_SET];
         if (wdata[CB_SET]) begin
            dir_a   <= wdata[CB_A];
            dir_b   <= wdata[CB_B];
            dir_chi <= wdata[CB_CHI];
            dir_clo <= wdata[CB_CLO];
         end
      end
   end

   // R4
   dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && wdata[CB_SET]) |=> $stable({dir_a, dir_b, dir_chi, dir_clo}));

   // R3
   flag_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (buf_off == $past(wdata[CB_SET])));
endmodule

// File: rtl/pio24_group.sv
module pio24_group #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         dir_in,
   input  logic         drv_allow,
   input  logic [W-1:0] pin_in,
   output logic [W-1:0] pin_out,
   output logic [W-1:0] pin_oe,
   output logic [W-1:0] rd_val
);
   initial begin
      if (W < 1) $error("group width must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  pin_out <= '0;
      else if (wr) pin_out <= wdata;
   end

   assign pin_oe = {W{~dir_in & drv_allow}};
   assign rd_val = dir_in ? pin_in : pin_out;

   // R6
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(pin_out));

   // R5
   oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|pin_oe) |-> (!dir_in && drv_allow));
endmodule

// File: rtl/pio24_port.sv
module pio24_port #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              drv_strap,
   input  logic [1:0]        addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata,
   input  logic [BYTE_W-1:0] pa_in,
   output logic [BYTE_W-1:0] pa_out,
   output logic [BYTE_W-1:0] pa_oe,
   input  logic [BYTE_W-1:0] pb_in,
   output logic [BYTE_W-1:0] pb_out,
   output logic [BYTE_W-1:0] pb_oe,
   input  logic [BYTE_W-1:0] pc_in,
   output logic [BYTE_W-1:0] pc_out,
   output logic [BYTE_W-1:0] pc_oe
);
   import pio24_pkg::*;

   localparam int unsigned NIB_W = BYTE_W / 2;

   initial begin
      if (BYTE_W % 2 != 0) $error("BYTE_W must be even");
   end

   logic dir_a, dir_b, dir_chi, dir_clo, buf_off, drv_allow;
   logic [BYTE_W-1:0] rd_a, rd_b, rd_c;
   logic [1:0] dir_c;

   assign drv_allow = drv_strap | ~buf_off;
   assign dir_c     = {dir_chi, dir_clo};

   pio24_ctrl #(.BYTE_W(BYTE_W)) ctrl_i (
      .clk(clk), .rst_n(rst_n),
      .wr(wr_en && addr == OFS_CTRL), .wdata(wdata),
      .dir_a(dir_a), .dir_b(dir_b), .dir_chi(dir_chi), .dir_clo(dir_clo),
      .buf_off(buf_off)
   );

   pio24_group #(.W(BYTE_W)) grp_a_i (
      .clk(clk), .rst_n(rst_n), .wr(wr_en && addr == OFS_A), .wdata(wdata),
      .dir_in(dir_a), .drv_allow(drv_allow), .pin_in(pa_in),
      .pin_out(pa_out), .pin_oe(pa_oe), .rd_val(rd_a)
   );

   pio24_group #(.W(BYTE_W)) grp_b_i (
      .clk(clk), .rst_n(rst_n), .wr(wr_en && addr == OFS_B), .wdata(wdata),
      .dir_in(dir_b), .drv_allow(drv_allow), .pin_in(pb_in),
      .pin_out(pb_out), .pin_oe(pb_oe), .rd_val(rd_b)
   );

   for (genvar n = 0; n < 2; n++) begin : g_cnib
      pio24_group #(.W(NIB_W)) nib_i (
         .clk(clk), .rst_n(rst_n), .wr(wr_en && addr == OFS_C),
         .wdata(wdata[n*NIB_W +: NIB_W]),
         .dir_in(dir_c[n]), .drv_allow(drv_allow),
         .pin_in(pc_in[n*NIB_W +: NIB_W]),
         .pin_out(pc_out[n*NIB_W +: NIB_W]),
         .pin_oe(pc_oe[n*NIB_W +: NIB_W]),
         .rd_val(rd_c[n*NIB_W +: NIB_W])
      );
   end

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         unique case (addr)
            OFS_A:   rdata = rd_a;
            OFS_B:   rdata = rd_b;
            OFS_C:   rdata = rd_c;
            default: rdata = '0;
         endcase
      end
   end

   // R8
   ctrl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en || addr == OFS_CTRL) |-> (rdata == '0));

   // R3
   gate_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!drv_strap && buf_off) |-> ((pa_oe | pb_oe | pc_oe) == '0));
endmodule

// File: tb/pio24_port_tb_top.sv
module pio24_port_tb_top;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0, rst_n = 1'b0, drv_strap = 1'b0;
   logic [1:0] addr = '0;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] wdata = '0, rdata;
   logic [7:0] pa_in = '0, pb_in = '0, pc_in = '0;
   logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
   int n_chk = 0, n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pio24_port dut_i (
      .clk(clk), .rst_n(rst_n), .drv_strap(drv_strap), .addr(addr),
      .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
      .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
      .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
      .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 d = rdata;
      rd_en = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      chk("R1 oe in reset", {pa_oe, pb_oe, pc_oe}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 oe after reset", {pa_oe, pb_oe, pc_oe}, 0);
      chk("R1 outputs zero", {pa_out, pb_out, pc_out}, 0);
      pa_in = 8'h3C;
      rd(2'd0, d);
      chk("R1 A reads pins (input)", d, 8'h3C);
      drv_strap = 1'b1; #1;
      chk("R1 all inputs: no oe with strap", {pa_oe, pb_oe, pc_oe}, 0);
      drv_strap = 1'b0;
   endtask

   task automatic t_enable_seq();
      logic [7:0] d;
      wr(2'd0, 8'hA5); wr(2'd1, 8'h5A); wr(2'd2, 8'hC3);
      chk("R6 A register", pa_out, 8'hA5);
      chk("R6 B register", pb_out, 8'h5A);
      chk("R6 C register", pc_out, 8'hC3);
      wr(2'd3, 8'h80);
      chk("R3 gated after 0x80", {pa_oe, pb_oe, pc_oe}, 0);
      wr(2'd3, 8'h00);
      chk("R2 R4 all outputs enabled", {pa_oe, pb_oe, pc_oe}, 24'hFFFFFF);
      chk("R4 data unchanged", {pa_out, pb_out, pc_out}, 24'hA55AC3);
      pa_in = 8'h00;
      rd(2'd0, d);
      chk("R7 output group reads register", d, 8'hA5);
      rd(2'd3, d);
      chk("R8 control reads zero", d, 8'h00);
      chk("R8 idle rdata zero", rdata, 8'h00);
      wr(2'd1, 8'h11);
      chk("R6 B rewrite", pb_out, 8'h11);
      chk("R6 A held", pa_out, 8'hA5);
   endtask

   task automatic t_mixed();
      logic [7:0] d;
      wr(2'd3, 8'h91);
      chk("R3 gated after 0x91", {pa_oe, pb_oe, pc_oe}, 0);
      wr(2'd3, 8'h00);
      chk("R2 A input", pa_oe, 8'h00);
      chk("R2 B output", pb_oe, 8'hFF);
      chk("R2 C hi out, lo in", pc_oe, 8'hF0);
      pc_in = 8'h7E;
      rd(2'd2, d);
      chk("R7 C mixed read", d, 8'hCE);
      pa_in = 8'h42;
      rd(2'd0, d);
      chk("R7 A live pins", d, 8'h42);
      pa_in = 8'h24;
      rd(2'd0, d);
      chk("R7 A live pins change", d, 8'h24);
      wr(2'd3, 8'h0F);
      chk("R4 no direction change on bit7=0", {pa_oe, pb_oe, pc_oe}, 24'h00FFF0);
      chk("R4 no bit set/reset on C", pc_out, 8'hC3);
   endtask

   task automatic t_strap();
      wr(2'd3, 8'h8A);
      chk("R3 gated after 0x8A", {pa_oe, pb_oe, pc_oe}, 0);
      drv_strap = 1'b1; #1;
      chk("R5 strap overrides flag", {pa_oe, pb_oe, pc_oe}, 24'hFF000F);
      drv_strap = 1'b0; #1;
      chk("R5 strap release regates", {pa_oe, pb_oe, pc_oe}, 0);
   endtask

   task automatic t_mode_bits();
      wr(2'd3, 8'hE4);
      chk("R9 mode bits gated like 0x80", {pa_oe, pb_oe, pc_oe}, 0);
      wr(2'd3, 8'h64);
      chk("R9 mode bits ignored", {pa_oe, pb_oe, pc_oe}, 24'hFFFFFF);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 2 + 2);
      t_reset();
      t_enable_seq();
      t_mixed();
      t_strap();
      t_mode_bits();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule